// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Nine-Bit Characters

This block turns bytes waiting in a transmit FIFO into asynchronous serial frames on a single output line. Whenever the line is free, it takes the next character from the FIFO through a read handshake and sends a frame made of a start bit, the data bits least significant bit first, an optional parity bit and one or two stop bits. Bit timing comes from an external baud tick, which is a one-cycle enable pulse. Every bit lasts a fixed number of those ticks.

Character length can be seven, eight or nine bits. In nine-bit operation the block has two variants. In the plain variant, each FIFO byte becomes one character and the top data bit is sent as zero. In the paired variant, two consecutive FIFO bytes make up one character: the first byte supplies the low eight bits and bit 0 of the second byte supplies the top bit. The configuration is captured when a character is taken, so changes made while a frame is on the line apply only to later frames.

Top module: `async_tx9`

## Requirements
- R1: After reset, tx_out is 1, busy is 0 and fifo_pop is 0. When all configuration inputs are zero, frames use 8 data bits, no parity and 1 stop bit.
- R2: Every frame is sent in this order: a start bit of 0, the data bits least significant bit first, the parity bit if enabled, then stop bits of 1. Each bit lasts TICKS_PER_BIT baud ticks (16 by default). tx_out rises only at an edge where baud_tick is high.
- R3: cfg_len encodes the character length: 0 or 3 selects 8 bits, 1 selects 7 bits (bits 6:0 of the byte are sent), and 2 selects 9 bits.
- R4: cfg_parity encodes parity: 0 none, 1 odd, 2 even, 3 mark (always 1), 4 space (always 0), and 5 to 7 none. Odd and even parity are computed over the data bits that are sent.
- R5: When cfg_two_stop is 1, the frame ends with two stop bits; otherwise it ends with one.
- R6: With 9 bits selected and cfg_wide at 0, each FIFO byte is one character. Data bit 8 is 0 and no parity bit is sent, whatever cfg_parity holds.
- R7: With 9 bits selected and cfg_wide at 1, two FIFO bytes are popped for one character. The first byte gives data bits 7:0 and bit 0 of the second byte gives data bit 8. While only the first byte has arrived, tx_out stays 1.
- R8: fifo_pop is a single-cycle pulse, asserted only while fifo_empty is 0. Exactly one FIFO entry is taken per character (two in paired mode), and the next character is taken only after the previous frame has finished.
- R9: busy rises in the same cycle as the first fifo_pop of a character and stays 1 until the end of the last stop bit, including any wait for a second byte.
- R10: cfg_len, cfg_parity, cfg_two_stop and cfg_wide are sampled when a character is taken from the FIFO. Changes during a frame do not alter that frame.
- R11: While busy is 0, tx_out is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_rd_data | input | BYTE_W (8) | Head entry of the transmit FIFO, valid while fifo_empty is 0 |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_pop | output | 1 | Single-cycle strobe that consumes the head entry |
| cfg_len | input | 2 | Character length code (R3) |
| cfg_parity | input | 3 | Parity code (R4) |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_wide | input | 1 | Build 9-bit characters from byte pairs |
| baud_tick | input | 1 | One-cycle bit-timing enable |
| tx_out | output | 1 | Serial line, idles high |
| busy | output | 1 | A character is in progress |

## Verification
The bench decodes each frame at mid-bit from tx_out and compares it with a frame it builds itself from the requirements. Paired mode is tested by supplying the second byte late. A design that starts the frame early, or pops the byte before it is present, shows activity on the line or a wrong ninth bit. Parity is set to odd during plain nine-bit operation, so a design that does not suppress parity sends an extra bit and the frame stops matching. The configuration is changed partway through a frame to catch designs that read it live. Back-to-back bytes and the FIFO count are used to catch over-eager popping, and busy is checked at mid-stop and just after the stop bit to catch a flag that drops early or hangs.

// File: rtl/async_tx9_pkg.sv
package async_tx9_pkg;

  localparam logic [1:0] LEN_8 = 2'd0;
  localparam logic [1:0] LEN_7 = 2'd1;
  localparam logic [1:0] LEN_9 = 2'd2;

  localparam logic [2:0] PAR_NONE  = 3'd0;
  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_EVEN  = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;
  localparam logic [2:0] PAR_SPACE = 3'd4;

  typedef struct packed {
    logic [1:0] len;
    logic [2:0] par;
    logic       two_stop;
    logic       wide;
  } frame_cfg_t;

  typedef enum logic [2:0] {
    F_IDLE,
    F_GAP,
    F_WAIT_HI,
    F_LOAD,
    F_RUN
  } fetch_state_e;

endpackage

// File: rtl/async_tx9_fetch.sv
module async_tx9_fetch
  import async_tx9_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] fifo_rd_data,
  input  logic              fifo_empty,
  input  frame_cfg_t        cfg_in,
  input  logic              frame_done,
  output logic              fifo_pop,
  output logic              busy,
  output logic              load,
  output frame_cfg_t        cfg_q,
  output logic [BYTE_W:0]   char_q
);

  fetch_state_e state, state_n;
  logic wide_pair;
  logic take_lo;
  logic take_hi;

  assign wide_pair = cfg_in.wide && (cfg_in.len == LEN_9);
  assign take_lo   = (state == F_IDLE) && !fifo_empty;
  assign take_hi   = (state == F_WAIT_HI) && !fifo_empty;
  assign load      = (state == F_LOAD);

  always_comb begin
    state_n = state;
    case (state)
      F_IDLE:    if (!fifo_empty) state_n = wide_pair ? F_GAP : F_LOAD;
      F_GAP:     state_n = F_WAIT_HI;
      F_WAIT_HI: if (!fifo_empty) state_n = F_LOAD;
      F_LOAD:    state_n = F_RUN;
      F_RUN:     if (frame_done) state_n = F_IDLE;
      default:   state_n = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= F_IDLE;
      fifo_pop <= 1'b0;
      busy     <= 1'b0;
      cfg_q    <= '0;
      char_q   <= '0;
    end else begin
      state    <= state_n;
      fifo_pop <= take_lo | take_hi;
      busy     <= (state_n != F_IDLE);
      if (take_lo) begin
        cfg_q  <= cfg_in;
        char_q <= {1'b0, fifo_rd_data};
      end
      if (take_hi) begin
        char_q[BYTE_W] <= fifo_rd_data[0];
      end
    end
  end

endmodule

// File: rtl/async_tx9_framer.sv
module async_tx9_framer
  import async_tx9_pkg::*;
#(
  parameter int CHAR_W  = 9,
  parameter int FRAME_W = CHAR_W + 4,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic [CHAR_W-1:0]  char_in,
  input  frame_cfg_t         cfg,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   frame_len
);

  int   n_data;
  logic ones_odd;
  logic par_on;
  logic par_bit;

  always_comb begin
    case (cfg.len)
      LEN_7:   n_data = CHAR_W - 2;
      LEN_9:   n_data = CHAR_W;
      default: n_data = CHAR_W - 1;
    endcase

    ones_odd = 1'b0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < n_data) ones_odd = ones_odd ^ char_in[i];
    end

    par_on = (cfg.len != LEN_9) &&
             ((cfg.par == PAR_ODD) || (cfg.par == PAR_EVEN) ||
              (cfg.par == PAR_MARK) || (cfg.par == PAR_SPACE));

    case (cfg.par)
      PAR_ODD:  par_bit = ~ones_odd;
      PAR_EVEN: par_bit = ones_odd;
      PAR_MARK: par_bit = 1'b1;
      default:  par_bit = 1'b0;
    endcase

    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < n_data) frame[i + 1] = char_in[i];
    end
    if (par_on) frame[n_data + 1] = par_bit;

    frame_len = LEN_W'(n_data + 2 + (par_on ? 1 : 0) + (cfg.two_stop ? 1 : 0));
  end

endmodule

// File: rtl/async_tx9_shifter.sv
module async_tx9_shifter #(
  parameter int TICKS_PER_BIT = 16,
  parameter int FRAME_W       = 13,
  parameter int LEN_W         = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               baud_tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   frame_len,
  output logic               tx_out,
  output logic               frame_done
);

  localparam int TCW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [TCW-1:0] TICK_LAST = TCW'(TICKS_PER_BIT - 1);

  logic               active;
  logic [TCW-1:0]     tcnt;
  logic [LEN_W-1:0]   left;
  logic [FRAME_W-1:0] shreg;
  logic               bit_end;

  assign bit_end    = active && baud_tick && (tcnt == TICK_LAST);
  assign frame_done = bit_end && (left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      tcnt   <= '0;
      left   <= '0;
      shreg  <= '1;
      tx_out <= 1'b1;
    end else if (load) begin
      tx_out <= frame[0];
      shreg  <= {1'b1, frame[FRAME_W-1:1]};
      left   <= frame_len - LEN_W'(1);
      tcnt   <= '0;
      active <= 1'b1;
    end else if (active && baud_tick) begin
      if (tcnt == TICK_LAST) begin
        tcnt <= '0;
        if (left == '0) begin
          active <= 1'b0;
          tx_out <= 1'b1;
        end else begin
          tx_out <= shreg[0];
          shreg  <= {1'b1, shreg[FRAME_W-1:1]};
          left   <= left - LEN_W'(1);
        end
      end else begin
        tcnt <= tcnt + TCW'(1);
      end
    end
  end

endmodule

// File: rtl/async_tx9.sv
module async_tx9
  import async_tx9_pkg::*;
#(
  parameter int BYTE_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] fifo_rd_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  input  logic [1:0]        cfg_len,
  input  logic [2:0]        cfg_parity,
  input  logic              cfg_two_stop,
  input  logic              cfg_wide,
  input  logic              baud_tick,
  output logic              tx_out,
  output logic              busy
);

  localparam int CHAR_W  = BYTE_W + 1;
  localparam int FRAME_W = CHAR_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  frame_cfg_t         cfg_in;
  frame_cfg_t         cfg_q;
  logic [CHAR_W-1:0]  char_q;
  logic               load;
  logic               frame_done;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   frame_len;

  assign cfg_in.len      = cfg_len;
  assign cfg_in.par      = cfg_parity;
  assign cfg_in.two_stop = cfg_two_stop;
  assign cfg_in.wide     = cfg_wide;

  async_tx9_fetch #(.BYTE_W(BYTE_W)) u_fetch (
    .clk          (clk),
    .rst          (rst),
    .fifo_rd_data (fifo_rd_data),
    .fifo_empty   (fifo_empty),
    .cfg_in       (cfg_in),
    .frame_done   (frame_done),
    .fifo_pop     (fifo_pop),
    .busy         (busy),
    .load         (load),
    .cfg_q        (cfg_q),
    .char_q       (char_q)
  );

  async_tx9_framer #(.CHAR_W(CHAR_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_framer (
    .char_in   (char_q),
    .cfg       (cfg_q),
    .frame     (frame),
    .frame_len (frame_len)
  );

  async_tx9_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shifter (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .load       (load),
    .frame      (frame),
    .frame_len  (frame_len),
    .tx_out     (tx_out),
    .frame_done (frame_done)
  );

endmodule

// File: rtl/async_tx9_checker.sv
module async_tx9_checker (
  input logic clk,
  input logic rst,
  input logic fifo_empty,
  input logic fifo_pop,
  input logic baud_tick,
  input logic tx_out,
  input logic busy
);

  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty); // R8

  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop); // R8

  AST_POP_BUSY: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> busy); // R9

  AST_BUSY_RISE_POP: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> fifo_pop); // R9

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_out); // R11

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_out) |-> $past(baud_tick)); // R2

endmodule

bind async_tx9 async_tx9_checker i_async_tx9_checker (
  .clk        (clk),
  .rst        (rst),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .baud_tick  (baud_tick),
  .tx_out     (tx_out),
  .busy       (busy)
);

// File: tb/test_async_tx9.sv
`timescale 1ns/1ps
module test_async_tx9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       baud_tick;
  logic [1:0] cfg_len = 2'd0;
  logic [2:0] cfg_parity = 3'd0;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_wide = 1'b0;
  logic       fifo_pop;
  logic       tx_out;
  logic       busy;
  logic       fifo_empty;
  logic [7:0] fifo_rd_data;

  logic [7:0] fq [0:63];
  int wp = 0;
  int rp = 0;
  assign fifo_empty   = (wp == rp);
  assign fifo_rd_data = fq[rp % 64];

  always @(posedge clk) if (fifo_pop && (wp != rp)) rp <= rp + 1;
  always @(posedge clk) if (rst) baud_tick <= 1'b0; else baud_tick <= ~baud_tick;

  async_tx9 i_async_tx9 (
    .clk(clk), .rst(rst), .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty),
    .fifo_pop(fifo_pop), .cfg_len(cfg_len), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .cfg_wide(cfg_wide), .baud_tick(baud_tick),
    .tx_out(tx_out), .busy(busy)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      check(1'b0, "watchdog", "run time", cyc, 150000);
      finish_run();
    end
  end

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    fq[wp % 64] = b;
    wp = wp + 1;
  endtask

  function automatic void exp_frame(input logic [8:0] d, input logic [1:0] l,
                                    input logic [2:0] p, input logic ts,
                                    output logic [12:0] f, output int n);
    int nd;
    int k;
    logic ones;
    nd = (l == 2'd1) ? 7 : (l == 2'd2) ? 9 : 8;
    f = '1;
    f[0] = 1'b0;
    ones = 1'b0;
    for (int i = 0; i < nd; i++) begin
      f[1 + i] = d[i];
      ones = ones ^ d[i];
    end
    k = 1 + nd;
    if (l != 2'd2 && p >= 3'd1 && p <= 3'd4) begin
      case (p)
        3'd1: f[k] = ~ones;
        3'd2: f[k] = ones;
        3'd3: f[k] = 1'b1;
        default: f[k] = 1'b0;
      endcase
      k++;
    end
    n = k + 1 + (ts ? 1 : 0);
  endfunction

  task automatic rx_frame(output logic [12:0] got, input int n, output bit ok);
    int w;
    w = 0;
    got = '1;
    ok = 1'b0;
    do begin
      @(negedge clk);
      w++;
    end while (tx_out !== 1'b0 && w < 6000);
    if (w >= 6000) return;
    repeat (16) @(negedge clk);
    got[0] = tx_out;
    for (int i = 1; i < n; i++) begin
      repeat (32) @(negedge clk);
      got[i] = tx_out;
    end
    ok = 1'b1;
  endtask

  task automatic run_frame(input string req, input logic [8:0] d, input bit last);
    logic [12:0] ef, got, mask;
    int n;
    bit ok;
    exp_frame(d, cfg_len, cfg_parity, cfg_two_stop, ef, n);
    rx_frame(got, n, ok);
    check(ok, req, "start bit seen", ok, 1);
    mask = (13'h1 << n) - 13'h1;
    check((got & mask) == (ef & mask), req, "frame bits", int'(got & mask), int'(ef & mask));
    check(busy === 1'b1, "R9", "busy in last stop", busy, 1);
    if (last) begin
      repeat (20) @(negedge clk);
      check(busy === 1'b0, "R9", "busy after stop", busy, 0);
      check(tx_out === 1'b1, "R11", "line idle", tx_out, 1);
    end
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic [2:0] p,
                         input logic ts, input logic wd);
    @(negedge clk);
    cfg_len = l; cfg_parity = p; cfg_two_stop = ts; cfg_wide = wd;
  endtask

  task automatic t_reset();
    bit seen;
    seen = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (tx_out !== 1'b1 || busy !== 1'b0 || fifo_pop !== 1'b0) seen = 1'b1;
    end
    check(tx_out === 1'b1, "R1", "reset tx_out", tx_out, 1);
    check(busy === 1'b0, "R1", "reset busy", busy, 0);
    check(!seen, "R1", "no pop after reset", seen, 0);
  endtask

  task automatic t_default();
    set_cfg(2'd0, 3'd0, 1'b0, 1'b0);
    push(8'hA5);
    run_frame("R1", 9'h0A5, 1'b1);
    push(8'h3E);
    run_frame("R2", 9'h03E, 1'b1);
  endtask

  task automatic t_seven_bit();
    set_cfg(2'd1, 3'd2, 1'b0, 1'b0);
    push(8'hD3);
    run_frame("R3", 9'h053, 1'b1);
    set_cfg(2'd3, 3'd0, 1'b0, 1'b0);
    push(8'h81);
    run_frame("R3", 9'h081, 1'b1);
  endtask

  task automatic t_parity();
    for (int p = 0; p < 6; p++) begin
      set_cfg(2'd0, 3'(p), 1'b0, 1'b0);
      push(8'h6B);
      run_frame("R4", 9'h06B, 1'b1);
    end
    set_cfg(2'd0, 3'd1, 1'b0, 1'b0);
    push(8'h6A);
    run_frame("R4", 9'h06A, 1'b1);
  endtask

  task automatic t_two_stop();
    set_cfg(2'd1, 3'd1, 1'b1, 1'b0);
    push(8'h40);
    run_frame("R5", 9'h040, 1'b1);
  endtask

  task automatic t_nine_narrow();
    set_cfg(2'd2, 3'd1, 1'b0, 1'b0);
    push(8'hFF);
    push(8'h81);
    run_frame("R6", 9'h0FF, 1'b0);
    run_frame("R6", 9'h081, 1'b1);
    check(wp == rp, "R6", "both bytes consumed", wp - rp, 0);
  endtask

  task automatic t_wide();
    bit quiet;
    set_cfg(2'd2, 3'd0, 1'b0, 1'b1);
    push(8'h3C);
    repeat (8) @(negedge clk);
    check(busy === 1'b1, "R9", "busy while waiting for pair", busy, 1);
    check(wp == rp, "R7", "first byte popped", wp - rp, 0);
    quiet = 1'b1;
    repeat (150) begin
      @(negedge clk);
      if (tx_out !== 1'b1) quiet = 1'b0;
    end
    check(quiet, "R7", "no partial character", quiet, 1);
    push(8'h03);
    run_frame("R7", 9'h13C, 1'b1);
    push(8'h55);
    push(8'hFE);
    run_frame("R7", 9'h055, 1'b1);
  endtask

  task automatic t_cfg_hold();
    set_cfg(2'd0, 3'd0, 1'b0, 1'b0);
    push(8'h0F);
    fork
      run_frame("R10", 9'h00F, 1'b1);
      begin
        repeat (60) @(negedge clk);
        cfg_len = 2'd1; cfg_parity = 3'd1; cfg_two_stop = 1'b1;
      end
    join
    set_cfg(2'd0, 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_back_to_back();
    set_cfg(2'd0, 3'd0, 1'b0, 1'b0);
    push(8'h11);
    push(8'h22);
    push(8'h33);
    repeat (10) @(negedge clk);
    check((wp - rp) == 2, "R8", "one byte taken per frame", wp - rp, 2);
    run_frame("R8", 9'h011, 1'b0);
    run_frame("R8", 9'h022, 1'b0);
    run_frame("R8", 9'h033, 1'b1);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_default();
    t_seven_bit();
    t_parity();
    t_two_stop();
    t_nine_narrow();
    t_wide();
    t_cfg_hold();
    t_back_to_back();
    finish_run();
  end

endmodule